// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This unit sits next to the fetch stage of a 32-bit processor. It decides which exception, interrupt or trap the core enters. The core can raise six kinds of entry request: reset, system break, reserved instruction, address fault, a numbered trap (0 to 15) and an external interrupt.

For the request with the highest priority, the unit does four things. It works out the handler address. It loads the backup program counter with the return address that suits that kind of entry. It clears the interrupt-enable and stack-mode bits. It sends fetch a one-cycle redirect. Two mode inputs move two of the handler addresses: a boot mode moves the reset entry, and a flash erase/write mode moves the external-interrupt entry. The core writes the interrupt-enable and stack-mode bits through a small status-write port.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `redirect_valid`, `redirect_addr`, `bpc`, `ie` and `sm` to 0.
- R2: Outside the special modes, the handler addresses are: reset 0x0000_0000, system break 0x0000_0010, reserved instruction 0x0000_0020, address fault 0x0000_0030, external interrupt 0x0000_0080.
- R3: Trap number n (0..15) goes to 0x0000_0040 + 4·n, so trap 15 goes to 0x0000_007C.
- R4: With `boot_mode` high, reset goes to 0x8000_0000. With `flash_ew_mode` high, the external interrupt goes to 0x0080_4000. Neither mode changes any other entry address.
- R5: The return address saved in `bpc` depends on the kind of entry:
  - a trap saves `cur_pc` + 4;
  - a reserved-instruction or address fault saves `cur_pc`;
  - an external interrupt or system break saves `next_pc`.
- R6: A reset entry leaves `bpc` unchanged.
- R7: When several requests arrive in the same cycle, the unit takes only one. The order from highest to lowest is reset, system break, address fault, reserved instruction, trap, external interrupt.
- R8: The unit takes an external interrupt only while `ie` is 1. A masked request causes no redirect and does not change `bpc`.
- R9: Every entry the unit takes clears `ie` and `sm` to 0. When no entry is taken, a pulse on `psw_wr` loads `ie` and `sm` from `psw_wr_ie` and `psw_wr_sm`.
- R10: `redirect_valid` and `redirect_addr` come from registers. They are valid for exactly the one cycle after the edge that takes the request, and `bpc` updates on that same edge. A cycle with no request that can be taken leaves `redirect_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the unit's own registers |
| req_reset | input | 1 | Reset entry request |
| req_sbi | input | 1 | System break request |
| req_ae | input | 1 | Address fault request |
| req_rie | input | 1 | Reserved-instruction request |
| req_trap | input | 1 | Trap instruction request |
| trap_num | input | 4 | Trap number |
| req_ext | input | 1 | External interrupt request |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the next instruction |
| boot_mode | input | 1 | Boot mode, which moves the reset entry |
| flash_ew_mode | input | 1 | Flash erase/write mode, which moves the external-interrupt entry |
| psw_wr | input | 1 | Status write strobe |
| psw_wr_ie | input | 1 | Interrupt-enable value to write |
| psw_wr_sm | input | 1 | Stack-mode value to write |
| redirect_valid | output | 1 | One-cycle redirect strobe to fetch |
| redirect_addr | output | 32 | Handler address |
| bpc | output | 32 | Backup program counter |
| ie | output | 1 | Interrupt enable |
| sm | output | 1 | Stack mode |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 4-bit trap number, the default entry bases and a return offset of 4. These values put both ends of the trap table (0x40 and 0x7C) and both moved bases within reach. Boot and flash modes are set against entries they must not move. Request sets that overlap walk the whole priority chain. Each stimulus gets its own `cur_pc` and `next_pc`, so that a wrong choice of saved return address shows up in `bpc`.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned N_EVT = 6;

  // index is the priority rank, 0 highest
  typedef enum logic [2:0] {
    EV_RESET = 3'd0,
    EV_SBI   = 3'd1,
    EV_AE    = 3'd2,
    EV_RIE   = 3'd3,
    EV_TRAP  = 3'd4,
    EV_EXT   = 3'd5,
    EV_NONE  = 3'd7
  } evt_kind_e;

  typedef enum logic [1:0] {
    RET_KEEP    = 2'd0,
    RET_CUR     = 2'd1,
    RET_NEXT    = 2'd2,
    RET_CUR_OFS = 2'd3
  } ret_sel_e;

  function automatic ret_sel_e ret_of(evt_kind_e k);
    case (k)
      EV_SBI, EV_EXT: return RET_NEXT;
      EV_AE, EV_RIE:  return RET_CUR;
      EV_TRAP:        return RET_CUR_OFS;
      default:        return RET_KEEP;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_rank
    assign grant[g]     = req[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req[g];
  end

  assign any = blocked[N];
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_entry_pkg::*;
#(
  parameter int unsigned       ADDR_W         = 32,
  parameter int unsigned       TRAP_W         = 4,
  parameter logic [ADDR_W-1:0] VEC_RESET      = 'h0000_0000,
  parameter logic [ADDR_W-1:0] VEC_RESET_BOOT = 'h8000_0000,
  parameter logic [ADDR_W-1:0] VEC_SBI        = 'h0000_0010,
  parameter logic [ADDR_W-1:0] VEC_RIE        = 'h0000_0020,
  parameter logic [ADDR_W-1:0] VEC_AE         = 'h0000_0030,
  parameter logic [ADDR_W-1:0] VEC_TRAP_BASE  = 'h0000_0040,
  parameter int unsigned       TRAP_STRIDE    = 4,
  parameter logic [ADDR_W-1:0] VEC_EXT        = 'h0000_0080,
  parameter logic [ADDR_W-1:0] VEC_EXT_FLASH  = 'h0080_4000
) (
  input  evt_kind_e         kind,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic              boot_mode,
  input  logic              flash_ew_mode,
  output logic [ADDR_W-1:0] vec
);
  localparam int unsigned N_TRAP = 1 << TRAP_W;

  logic [ADDR_W-1:0] trap_tbl [N_TRAP];

  for (genvar g = 0; g < N_TRAP; g++) begin : g_trap
    assign trap_tbl[g] = VEC_TRAP_BASE + ADDR_W'(g * TRAP_STRIDE);
  end

  always_comb begin
    case (kind)
      EV_RESET: vec = boot_mode ? VEC_RESET_BOOT : VEC_RESET;
      EV_SBI:   vec = VEC_SBI;
      EV_AE:    vec = VEC_AE;
      EV_RIE:   vec = VEC_RIE;
      EV_TRAP:  vec = trap_tbl[trap_num];
      EV_EXT:   vec = flash_ew_mode ? VEC_EXT_FLASH : VEC_EXT;
      default:  vec = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
  import exc_entry_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned TRAP_RET_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  ret_sel_e          ret_sel,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              psw_wr,
  input  logic              psw_wr_ie,
  input  logic              psw_wr_sm,
  output logic [ADDR_W-1:0] bpc,
  output logic              ie,
  output logic              sm
);
  logic [ADDR_W-1:0] ret_addr;

  always_comb begin
    case (ret_sel)
      RET_CUR:     ret_addr = cur_pc;
      RET_NEXT:    ret_addr = next_pc;
      RET_CUR_OFS: ret_addr = cur_pc + ADDR_W'(TRAP_RET_OFS);
      default:     ret_addr = bpc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bpc <= '0;
      ie  <= 1'b0;
      sm  <= 1'b0;
    end else if (take) begin
      bpc <= ret_addr;
      ie  <= 1'b0;
      sm  <= 1'b0;
    end else if (psw_wr) begin
      ie  <= psw_wr_ie;
      sm  <= psw_wr_sm;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int unsigned       ADDR_W         = 32,
  parameter int unsigned       TRAP_W         = 4,
  parameter logic [ADDR_W-1:0] VEC_RESET      = 'h0000_0000,
  parameter logic [ADDR_W-1:0] VEC_RESET_BOOT = 'h8000_0000,
  parameter logic [ADDR_W-1:0] VEC_SBI        = 'h0000_0010,
  parameter logic [ADDR_W-1:0] VEC_RIE        = 'h0000_0020,
  parameter logic [ADDR_W-1:0] VEC_AE         = 'h0000_0030,
  parameter logic [ADDR_W-1:0] VEC_TRAP_BASE  = 'h0000_0040,
  parameter int unsigned       TRAP_STRIDE    = 4,
  parameter logic [ADDR_W-1:0] VEC_EXT        = 'h0000_0080,
  parameter logic [ADDR_W-1:0] VEC_EXT_FLASH  = 'h0080_4000,
  parameter int unsigned       TRAP_RET_OFS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_reset,
  input  logic              req_sbi,
  input  logic              req_ae,
  input  logic              req_rie,
  input  logic              req_trap,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic              req_ext,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              boot_mode,
  input  logic              flash_ew_mode,
  input  logic              psw_wr,
  input  logic              psw_wr_ie,
  input  logic              psw_wr_sm,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic [ADDR_W-1:0] bpc,
  output logic              ie,
  output logic              sm
);
  logic [N_EVT-1:0]  req_vec;
  logic [N_EVT-1:0]  grant;
  logic              take;
  evt_kind_e         kind;
  logic [ADDR_W-1:0] vec;

  assign req_vec = {req_ext & ie, req_trap, req_rie, req_ae, req_sbi, req_reset};

  exc_prio_arb #(.N(N_EVT)) u_arb (
    .req   (req_vec),
    .grant (grant),
    .any   (take)
  );

  always_comb begin
    kind = EV_NONE;
    for (int i = N_EVT - 1; i >= 0; i--) begin
      if (grant[i]) kind = evt_kind_e'(3'(i));
    end
  end

  exc_vec_gen #(
    .ADDR_W         (ADDR_W),
    .TRAP_W         (TRAP_W),
    .VEC_RESET      (VEC_RESET),
    .VEC_RESET_BOOT (VEC_RESET_BOOT),
    .VEC_SBI        (VEC_SBI),
    .VEC_RIE        (VEC_RIE),
    .VEC_AE         (VEC_AE),
    .VEC_TRAP_BASE  (VEC_TRAP_BASE),
    .TRAP_STRIDE    (TRAP_STRIDE),
    .VEC_EXT        (VEC_EXT),
    .VEC_EXT_FLASH  (VEC_EXT_FLASH)
  ) u_vec (
    .kind          (kind),
    .trap_num      (trap_num),
    .boot_mode     (boot_mode),
    .flash_ew_mode (flash_ew_mode),
    .vec           (vec)
  );

  exc_ctx_regs #(
    .ADDR_W       (ADDR_W),
    .TRAP_RET_OFS (TRAP_RET_OFS)
  ) u_ctx (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .ret_sel   (ret_of(kind)),
    .cur_pc    (cur_pc),
    .next_pc   (next_pc),
    .psw_wr    (psw_wr),
    .psw_wr_ie (psw_wr_ie),
    .psw_wr_sm (psw_wr_sm),
    .bpc       (bpc),
    .ie        (ie),
    .sm        (sm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
    end else begin
      redirect_valid <= take;
      redirect_addr  <= take ? vec : '0;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned       ADDR_W         = 32,
  parameter int unsigned       TRAP_W         = 4,
  parameter logic [ADDR_W-1:0] VEC_RESET      = 'h0000_0000,
  parameter logic [ADDR_W-1:0] VEC_RESET_BOOT = 'h8000_0000,
  parameter int unsigned       TRAP_RET_OFS   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_reset,
  input logic              req_sbi,
  input logic              req_ae,
  input logic              req_rie,
  input logic              req_trap,
  input logic              req_ext,
  input logic [ADDR_W-1:0] cur_pc,
  input logic              boot_mode,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_addr,
  input logic [ADDR_W-1:0] bpc,
  input logic              ie,
  input logic              sm
);
  logic above_trap, accept;
  assign above_trap = req_reset | req_sbi | req_ae | req_rie;
  assign accept     = above_trap | req_trap | (req_ext & ie);

  a_r10_accept_redirect: assert property (@(posedge clk) disable iff (rst)
    accept |=> redirect_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !redirect_valid);

  a_r9_clear_flags: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!ie && !sm));

  a_r5_trap_return: assert property (@(posedge clk) disable iff (rst)
    (req_trap && !above_trap) |=> bpc == $past(cur_pc) + ADDR_W'(TRAP_RET_OFS));

  a_r6_reset_keeps_bpc: assert property (@(posedge clk) disable iff (rst)
    req_reset |=> (bpc == $past(bpc) &&
      redirect_addr == ($past(boot_mode) ? VEC_RESET_BOOT : VEC_RESET)));

  a_r8_masked_ext: assert property (@(posedge clk) disable iff (rst)
    (req_ext && !ie && !above_trap && !req_trap) |=> (!redirect_valid && $stable(bpc)));
endmodule

bind exc_entry_unit exc_entry_chk #(
  .ADDR_W         (ADDR_W),
  .TRAP_W         (TRAP_W),
  .VEC_RESET      (VEC_RESET),
  .VEC_RESET_BOOT (VEC_RESET_BOOT),
  .TRAP_RET_OFS   (TRAP_RET_OFS)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_reset      (req_reset),
  .req_sbi        (req_sbi),
  .req_ae         (req_ae),
  .req_rie        (req_rie),
  .req_trap       (req_trap),
  .req_ext        (req_ext),
  .cur_pc         (cur_pc),
  .boot_mode      (boot_mode),
  .redirect_valid (redirect_valid),
  .redirect_addr  (redirect_addr),
  .bpc            (bpc),
  .ie             (ie),
  .sm             (sm)
);

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_reset = 0, req_sbi = 0, req_ae = 0, req_rie = 0, req_trap = 0, req_ext = 0;
  logic [3:0]  trap_num = '0;
  logic [31:0] cur_pc = '0, next_pc = '0;
  logic        boot_mode = 0, flash_ew_mode = 0;
  logic        psw_wr = 0, psw_wr_ie = 0, psw_wr_sm = 0;
  logic        redirect_valid, ie, sm;
  logic [31:0] redirect_addr, bpc;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  exc_entry_unit u_exc_entry_unit (
    .clk(clk), .rst(rst),
    .req_reset(req_reset), .req_sbi(req_sbi), .req_ae(req_ae), .req_rie(req_rie),
    .req_trap(req_trap), .trap_num(trap_num), .req_ext(req_ext),
    .cur_pc(cur_pc), .next_pc(next_pc),
    .boot_mode(boot_mode), .flash_ew_mode(flash_ew_mode),
    .psw_wr(psw_wr), .psw_wr_ie(psw_wr_ie), .psw_wr_sm(psw_wr_sm),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .bpc(bpc), .ie(ie), .sm(sm)
  );

  // [47:42] req {reset,sbi,ae,rie,trap,ext}  [41:38] trap_num  [37] boot  [36] flash
  // [35] ie before  [34] expected valid  [33:2] expected addr  [1:0] bpc source
  // bpc source: 0 keep, 1 cur_pc, 2 next_pc, 3 cur_pc+4
  localparam int NV = 18;
  localparam logic [47:0] VEC [NV] = '{
    {6'b100000, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 2'd0},  // R2 R6 reset
    {6'b100000, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 2'd0},  // R4 boot reset
    {6'b010000, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0010, 2'd2},  // R2 R5 sbi
    {6'b000100, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0020, 2'd1},  // R2 R5 rie
    {6'b001000, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0030, 2'd1},  // R2 R5 ae
    {6'b000010, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0040, 2'd3},  // R3 trap0
    {6'b000010, 4'd15, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_007C, 2'd3},  // R3 trap15
    {6'b000010, 4'd7,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_005C, 2'd3},  // R3 trap7
    {6'b000001, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0080, 2'd2},  // R2 R5 ext
    {6'b000001, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 32'h0080_4000, 2'd2},  // R4 flash ext
    {6'b000001, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 2'd0},  // R8 masked
    {6'b111111, 4'd2,  1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 2'd0},  // R7 all
    {6'b011111, 4'd2,  1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0010, 2'd2},  // R7 sbi wins
    {6'b001100, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0030, 2'd1},  // R7 ae over rie
    {6'b000110, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0020, 2'd1},  // R7 rie over trap
    {6'b000011, 4'd3,  1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_004C, 2'd3},  // R7 trap over ext
    {6'b010000, 4'd0,  1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0010, 2'd2},  // R4 modes ignored
    {6'b000010, 4'd5,  1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0054, 2'd3}   // R4 modes ignored
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_reqs();
    {req_reset, req_sbi, req_ae, req_rie, req_trap, req_ext} = '0;
    boot_mode = 0; flash_ew_mode = 0; trap_num = '0;
  endtask

  task automatic set_psw(logic ie_v, logic sm_v);
    @(negedge clk);
    psw_wr = 1; psw_wr_ie = ie_v; psw_wr_sm = sm_v;
    @(negedge clk);
    psw_wr = 0;
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none
  end

  initial begin
    logic [31:0] model_bpc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(redirect_valid), 32'd0);
    check("R1 addr", redirect_addr, 32'd0);
    check("R1 bpc", bpc, 32'd0);
    check("R1 ie", 32'(ie), 32'd0);
    check("R1 sm", 32'(sm), 32'd0);
    rst = 0;
    model_bpc = '0;

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      logic [31:0] cp, np, exp_bpc;
      v  = VEC[i];
      cp = 32'h1000_0000 + 32'(i) * 32'h100;
      np = cp + 32'h2;
      set_psw(v[35], 1'b1);
      {req_reset, req_sbi, req_ae, req_rie, req_trap, req_ext} = v[47:42];
      trap_num = v[41:38]; boot_mode = v[37]; flash_ew_mode = v[36];
      cur_pc = cp; next_pc = np;
      @(negedge clk);
      clear_reqs();
      case (v[1:0])
        2'd1:    exp_bpc = cp;
        2'd2:    exp_bpc = np;
        2'd3:    exp_bpc = cp + 32'd4;
        default: exp_bpc = model_bpc;
      endcase
      if (v[34]) model_bpc = exp_bpc;
      check($sformatf("R10 valid v%0d", i), 32'(redirect_valid), 32'(v[34]));
      if (v[34]) check($sformatf("R2 R3 R4 R7 addr v%0d", i), redirect_addr, v[33:2]);
      check($sformatf("R5 R6 R8 bpc v%0d", i), bpc, model_bpc);
      check($sformatf("R9 ie v%0d", i), 32'(ie), v[34] ? 32'd0 : 32'(v[35]));
      check($sformatf("R9 sm v%0d", i), 32'(sm), v[34] ? 32'd0 : 32'd1);
      @(negedge clk);
      check($sformatf("R10 drop v%0d", i), 32'(redirect_valid), 32'd0);
    end

    // R10 back-to-back entries each give one strobe
    @(negedge clk);
    req_trap = 1; trap_num = 4'd1; cur_pc = 32'h2000_0000;
    @(negedge clk);
    req_trap = 0; req_rie = 1; cur_pc = 32'h2000_0100;
    check("R10 b2b first", redirect_addr, 32'h0000_0044);
    check("R5 b2b bpc", bpc, 32'h2000_0004);
    @(negedge clk);
    clear_reqs();
    check("R10 b2b second", redirect_addr, 32'h0000_0020);
    check("R5 b2b bpc2", bpc, 32'h2000_0100);
    @(negedge clk);
    check("R10 b2b end", 32'(redirect_valid), 32'd0);

    // R9 status write sets ie and sm when no entry
    set_psw(1'b1, 1'b1);
    check("R9 psw ie", 32'(ie), 32'd1);
    check("R9 psw sm", 32'(sm), 32'd1);

    // R1 reset mid-operation with a request pending
    rst = 1; req_ae = 1;
    @(negedge clk);
    check("R1 rerst valid", 32'(redirect_valid), 32'd0);
    check("R1 rerst bpc", bpc, 32'd0);
    check("R1 rerst ie", 32'(ie), 32'd0);
    rst = 0; req_ae = 0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule